// File: doc/BRIEF.md
# Hardware LIFO Stack Controller

This block keeps a last-in, first-out stack in a small synchronous memory inside the block. A producer offers words through a valid/ready push port, and a consumer asks for the top word with a pop request. The popped word comes back one clock later with a valid strobe. The block also reports whether the stack is empty or full, shows the current stack pointer, and raises a one-cycle error pulse when a request cannot be served.

Two parameters set the pointer convention at build time. `GROW_UP` chooses whether pushes move the pointer toward higher or lower addresses. `LAST_FULL` chooses whether the pointer names the most recently written slot, or the free slot where the next push will land. The convention decides the order of the pointer step and the memory access. With a last-full pointer, a push steps first and then writes at the new pointer, and a pop reads at the pointer before it steps back. With a next-empty pointer, a push writes at the pointer and then steps, and a pop steps back first and then reads. `DEPTH` must be a power of two, and the pointer wraps modulo `DEPTH`.

Back-pressure rules: `push_ready_o` is high exactly when the stack is not full. A push is taken on a clock edge where `push_valid_i` and `push_ready_o` are both high and `pop_req_i` is low. Holding `push_valid_i` high while not ready counts as an overflow attempt. The pop side has no back-pressure: the consumer must accept `pop_data_o` in the cycle where `pop_valid_o` is high.

Top module: `lifo_stack_ctrl`

## Requirements
- R1: After reset, `empty_o` is 1, `full_o` is 0, `err_o` is 0, `pop_valid_o` is 0, and `sp_o` holds its empty value, which depends on the convention. Grow-up with last-full gives DEPTH-1. Grow-up with next-empty gives 0. Grow-down with last-full gives 0. Grow-down with next-empty gives DEPTH-1.
- R2: With n words stored, `sp_o` is the following value modulo DEPTH. Grow-up with last-full gives n-1. Grow-up with next-empty gives n. Grow-down with last-full gives -n. Grow-down with next-empty gives DEPTH-1-n. Each accepted push moves the pointer one step in the growth direction, and each accepted pop moves it one step back.
- R3: An accepted pop returns the most recently pushed word that has not yet been popped. `pop_valid_o` is high for exactly the one cycle after the accepted pop, with that word on `pop_data_o`.
- R4: A push attempt while full is ignored: the pointer and the stored words are unchanged, and `err_o` is high for the one following cycle only. `push_ready_o` equals the inverse of `full_o`.
- R5: A pop request while empty is ignored. `err_o` is high for the one following cycle, and `pop_valid_o` stays low.
- R6: A cycle with both `push_valid_i` and `pop_req_i` high is an error. Nothing is pushed or popped, the pointer stays where it was, `err_o` pulses in the next cycle, and `pop_valid_o` stays low.
- R7: `empty_o` is high exactly when zero words are stored. `full_o` is high exactly when DEPTH words are stored. The two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| push_valid_i | input | 1 | Push offer is valid |
| push_ready_o | output | 1 | Stack can take a push (not full) |
| push_data_i | input | DATA_W | Word to push |
| pop_req_i | input | 1 | Request to pop the top word |
| pop_valid_o | output | 1 | `pop_data_o` holds a popped word this cycle |
| pop_data_o | output | DATA_W | Popped word |
| empty_o | output | 1 | No words stored |
| full_o | output | 1 | DEPTH words stored |
| sp_o | output | $clog2(DEPTH) | Current stack pointer |
| err_o | output | 1 | One-cycle pulse after a rejected request |

## Verification
The bench runs all four pointer conventions side by side on the same stimulus and computes the expected pointer arithmetically from the word count. A design that swapped the step-then-access order would show the wrong pointer, or would return a neighbouring slot's word on pop. The bench fills the stack past its limit and drains it past empty. A design that wrapped the pointer there would corrupt the bottom entry, and one that let a request through would assert a false `pop_valid_o`. Pushes and pops issued in the same cycle are mixed in as well: a design that served either half would move the pointer or lose a word.

// File: rtl/lifo_stack_pkg.sv
package lifo_stack_pkg;

  typedef enum logic [1:0] {
    STK_IDLE = 2'd0,
    STK_PUSH = 2'd1,
    STK_POP  = 2'd2,
    STK_REJ  = 2'd3
  } stk_op_e;

  function automatic stk_op_e stk_classify(input logic push_v, input logic pop_r,
                                           input logic is_empty, input logic is_full);
    if (push_v && pop_r)         return STK_REJ;
    else if (push_v && is_full)  return STK_REJ;
    else if (push_v)             return STK_PUSH;
    else if (pop_r && is_empty)  return STK_REJ;
    else if (pop_r)              return STK_POP;
    else                         return STK_IDLE;
  endfunction

endpackage

// File: rtl/lifo_stack_ptr.sv
module lifo_stack_ptr
  import lifo_stack_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter bit GROW_UP   = 1'b1,
  parameter bit LAST_FULL = 1'b1,
  localparam int ADDR_W   = $clog2(DEPTH),
  localparam int CNT_W    = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  stk_op_e           op,
  output logic [ADDR_W-1:0] sp,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              is_empty,
  output logic              is_full
);

  localparam logic [ADDR_W-1:0] TOP_ADDR = ADDR_W'(DEPTH - 1);
  localparam logic [ADDR_W-1:0] SP_RESET =
    (LAST_FULL == GROW_UP) ? TOP_ADDR : '0;

  logic [ADDR_W-1:0] sp_fwd, sp_back;
  logic [CNT_W-1:0]  count;

  // Forward is the growth direction; back undoes one push.
  generate
    if (GROW_UP) begin : g_up
      assign sp_fwd  = sp + ADDR_W'(1);
      assign sp_back = sp - ADDR_W'(1);
    end else begin : g_down
      assign sp_fwd  = sp - ADDR_W'(1);
      assign sp_back = sp + ADDR_W'(1);
    end
  endgenerate

  // Access order: last-full steps before writing and reads before stepping;
  // next-empty writes before stepping and steps before reading.
  generate
    if (LAST_FULL) begin : g_last_full
      assign wr_addr = sp_fwd;
      assign rd_addr = sp;
    end else begin : g_next_empty
      assign wr_addr = sp;
      assign rd_addr = sp_back;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp    <= SP_RESET;
      count <= '0;
    end else begin
      case (op)
        STK_PUSH: begin
          sp    <= sp_fwd;
          count <= count + CNT_W'(1);
        end
        STK_POP: begin
          sp    <= sp_back;
          count <= count - CNT_W'(1);
        end
        default: ;
      endcase
    end
  end

  assign is_empty = (count == '0);
  assign is_full  = (count == CNT_W'(DEPTH));

endmodule

// File: rtl/lifo_stack_ram.sv
module lifo_stack_ram #(
  parameter int DATA_W  = 8,
  parameter int DEPTH   = 8,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) store[wr_addr] <= wr_data;
    if (rd_en) rd_data <= store[rd_addr];
  end

endmodule

// File: rtl/lifo_stack_ctrl.sv
module lifo_stack_ctrl
  import lifo_stack_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int DEPTH     = 8,
  parameter bit GROW_UP   = 1'b1,
  parameter bit LAST_FULL = 1'b1,
  localparam int ADDR_W   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_valid_i,
  output logic              push_ready_o,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              pop_req_i,
  output logic              pop_valid_o,
  output logic [DATA_W-1:0] pop_data_o,
  output logic              empty_o,
  output logic              full_o,
  output logic [ADDR_W-1:0] sp_o,
  output logic              err_o
);

  stk_op_e           op;
  logic              is_empty, is_full;
  logic [ADDR_W-1:0] wr_addr, rd_addr;

  assign op = stk_classify(push_valid_i, pop_req_i, is_empty, is_full);

  lifo_stack_ptr #(
    .DEPTH     (DEPTH),
    .GROW_UP   (GROW_UP),
    .LAST_FULL (LAST_FULL)
  ) ptr_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .op       (op),
    .sp       (sp_o),
    .wr_addr  (wr_addr),
    .rd_addr  (rd_addr),
    .is_empty (is_empty),
    .is_full  (is_full)
  );

  lifo_stack_ram #(
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH)
  ) ram_i (
    .clk     (clk),
    .wr_en   (op == STK_PUSH),
    .wr_addr (wr_addr),
    .wr_data (push_data_i),
    .rd_en   (op == STK_POP),
    .rd_addr (rd_addr),
    .rd_data (pop_data_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_o       <= 1'b0;
      pop_valid_o <= 1'b0;
    end else begin
      err_o       <= (op == STK_REJ);
      pop_valid_o <= (op == STK_POP);
    end
  end

  assign empty_o      = is_empty;
  assign full_o       = is_full;
  assign push_ready_o = ~is_full;

endmodule

// File: rtl/lifo_stack_ctrl_chk.sv
module lifo_stack_ctrl_chk #(
  parameter bit GROW_UP = 1'b1,
  parameter int ADDR_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              push_valid_i,
  input logic              push_ready_o,
  input logic              pop_req_i,
  input logic              pop_valid_o,
  input logic              empty_o,
  input logic              full_o,
  input logic [ADDR_W-1:0] sp_o,
  input logic              err_o
);

  logic [ADDR_W-1:0] step_fwd;
  assign step_fwd = GROW_UP ? ADDR_W'(1) : {ADDR_W{1'b1}};

  p_flags_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(empty_o && full_o));

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid_i && full_o && !pop_req_i) |=> (err_o && $stable(sp_o)));

  p_ready_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    push_ready_o != full_o);

  p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req_i && empty_o && !push_valid_i) |=> (err_o && !pop_valid_o && $stable(sp_o)));

  p_both_reject_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid_i && pop_req_i) |=> (err_o && !pop_valid_o && $stable(sp_o)));

  p_pop_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req_i && !push_valid_i && !empty_o) |=> (pop_valid_o && !err_o));

  p_push_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid_i && !full_o && !pop_req_i) |=> (sp_o == $past(sp_o) + step_fwd));

  p_pop_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req_i && !empty_o && !push_valid_i) |=> (sp_o == $past(sp_o) - step_fwd));

endmodule

bind lifo_stack_ctrl lifo_stack_ctrl_chk #(
  .GROW_UP (GROW_UP),
  .ADDR_W  (ADDR_W)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .push_valid_i (push_valid_i),
  .push_ready_o (push_ready_o),
  .pop_req_i    (pop_req_i),
  .pop_valid_o  (pop_valid_o),
  .empty_o      (empty_o),
  .full_o       (full_o),
  .sp_o         (sp_o),
  .err_o        (err_o)
);

// File: tb/lifo_stack_ctrl_tb_top.sv
module lifo_stack_ctrl_tb_top;

  localparam int D  = 4;
  localparam int DW = 8;
  localparam int NC = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          push_v = 1'b0;
  logic          pop_r  = 1'b0;
  logic [DW-1:0] pdata  = '0;

  logic [DW-1:0] pd  [NC];
  logic [1:0]    spv [NC];
  logic          em  [NC];
  logic          fu  [NC];
  logic          er  [NC];
  logic          pv  [NC];
  logic          rdy [NC];

  // Index bit 1 selects growth direction, bit 0 selects last-full.
  for (genvar g = 0; g < NC; g++) begin : gen_cfg
    lifo_stack_ctrl #(
      .DATA_W    (DW),
      .DEPTH     (D),
      .GROW_UP   (g[1]),
      .LAST_FULL (g[0])
    ) dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .push_valid_i (push_v),
      .push_ready_o (rdy[g]),
      .push_data_i  (pdata),
      .pop_req_i    (pop_r),
      .pop_valid_o  (pv[g]),
      .pop_data_o   (pd[g]),
      .empty_o      (em[g]),
      .full_o       (fu[g]),
      .sp_o         (spv[g]),
      .err_o        (er[g])
    );
  end

  int n_checks = 0;
  int n_fail   = 0;

  int model [D];
  int cnt = 0;

  task automatic chk(input string req, input int cfg, input string what,
                     input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s cfg%0d %s: actual %0d expected %0d", req, cfg, what, act, exp);
    end
  endtask

  function automatic int exp_sp(input int cfg, input int n);
    case (cfg)
      3: return (n - 1) & (D - 1);
      2: return n & (D - 1);
      1: return (-n) & (D - 1);
      default: return (D - 1 - n) & (D - 1);
    endcase
  endfunction

  // One operation, all outputs checked in the cycle after the edge.
  task automatic do_op(input bit pu, input bit po, input logic [DW-1:0] d, input string tag);
    bit bad, popped;
    int top;
    @(negedge clk);
    push_v = pu; pop_r = po; pdata = d;
    bad = (pu && po) || (pu && cnt == D) || (po && !pu && cnt == 0);
    popped = 1'b0;
    top = 0;
    if (!bad && pu) begin model[cnt] = int'(d); cnt++; end
    if (!bad && po) begin cnt--; top = model[cnt]; popped = 1'b1; end
    @(negedge clk);
    for (int c = 0; c < NC; c++) begin
      chk(bad && pu && !po ? "R4" : bad && po && !pu ? "R5" : bad ? "R6" : "R2",
          c, {tag, " err"}, int'(er[c]), int'(bad));
      chk("R2", c, {tag, " sp"}, int'(spv[c]), exp_sp(c, cnt));
      chk("R7", c, {tag, " empty"}, int'(em[c]), int'(cnt == 0));
      chk("R7", c, {tag, " full"}, int'(fu[c]), int'(cnt == D));
      chk("R4", c, {tag, " ready"}, int'(rdy[c]), int'(cnt != D));
      chk("R3", c, {tag, " pop_valid"}, int'(pv[c]), int'(popped));
      if (popped) chk("R3", c, {tag, " pop_data"}, int'(pd[c]), top);
    end
    push_v = 1'b0; pop_r = 1'b0;
  endtask

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int c = 0; c < NC; c++) begin
      chk("R1", c, "reset empty", int'(em[c]), 1);
      chk("R1", c, "reset full", int'(fu[c]), 0);
      chk("R1", c, "reset err", int'(er[c]), 0);
      chk("R1", c, "reset pop_valid", int'(pv[c]), 0);
      chk("R1", c, "reset sp", int'(spv[c]), exp_sp(c, 0));
    end
    // R5: underflow on an empty stack.
    do_op(1'b0, 1'b1, 8'h00, "underflow");
    do_op(1'b0, 1'b0, 8'h00, "idle after error");
    // R6 on an empty stack, then fill past the limit for R4.
    do_op(1'b1, 1'b1, 8'h99, "both while empty");
    for (int i = 0; i < D + 2; i++) do_op(1'b1, 1'b0, 8'(8'h40 + i), "fill");
    do_op(1'b1, 1'b1, 8'h77, "both while full");
    do_op(1'b0, 1'b0, 8'h00, "idle while full");
    // Drain past empty for R3 and R5.
    for (int i = 0; i < D + 2; i++) do_op(1'b0, 1'b1, 8'h00, "drain");
    // Alternating push and pop at shallow depth.
    for (int i = 0; i < 6; i++) begin
      do_op(1'b1, 1'b0, 8'(8'hA0 + i), "alt push");
      do_op(1'b0, 1'b1, 8'h00, "alt pop");
    end
    // Pseudo-random sweep of all four request kinds.
    lfsr = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (lfsr[1:0])
        2'd0: do_op(1'b0, 1'b0, lfsr[15:8], "rand idle");
        2'd1: do_op(1'b1, lfsr[7] & lfsr[9] & lfsr[11], lfsr[15:8], "rand push");
        2'd2: do_op(1'b0, 1'b1, lfsr[15:8], "rand pop");
        default: do_op(1'b1, 1'b0, lfsr[15:8], "rand push2");
      endcase
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule